// File: doc/BRIEF.md
# Timing Broadcast Frame Generator

This block drives a two-channel timing link. Every bunch clock it issues one slot on channel A, a low-latency first-level trigger accept bit, and one slot on channel B, the broadcast channel. The A slot precedes the B slot within the clock period. Channel B carries framed, Hamming-protected commands, one bit per clock, and rests at logic 1 between frames.

Four upstream sources post requests with a valid/ready handshake. Three of them post short broadcasts with 8 data bits in a 16-bit frame: counter resets, second-level trigger decisions and control commands such as front-end resets or calibration pulses. One source posts long broadcasts that carry an 8-bit qualifier and a 16-bit network destination address in a 42-bit frame. A fixed-priority arbiter picks the next frame when the channel is free. A frame that has started is always sent to the end.

Top module: `tbf_gen`

## Requirements
- R1: After reset `lane_a` is 0, `lane_b` is 1, and no ready output is asserted while no valid input is high.
- R2: In every cycle `lane_a` equals the value `trig_accept` had in the previous clock cycle, whether or not a frame is on channel B.
- R3: When no frame is being sent, `lane_b` is 1.
- R4: A short frame is 16 bits, sent in this order: 0 (start), 0 (format), data bits 7 down to 0, five check bits, 1 (stop).
- R5: Check bits: data bit j (j = 0 first) is given the j-th integer from 3 upward that is not a power of two. Check h_i (i = 0..4) is the XOR of the data bits whose position has bit i set. The overall bit is the XOR of all data bits and all h_i. A short frame sends the overall bit first, then h3, h2, h1, h0.
- R6: A long frame is 42 bits, sent in this order: 0 (start), 1 (format), qualifier bits 7..0, address bits 15..0, six check bits, nine reserved 0 bits, 1 (stop).
- R7: The long-frame check bits follow the rule in R5 over the 24 bits {address (bits 0..15), qualifier (bits 16..23)}. They are sent as the overall bit first, then h4 down to h0.
- R8: Priority from highest to lowest is counter reset, second-level decision, control command, destination. At most one ready is asserted in a cycle. It is asserted only with its own valid, and for exactly one cycle per accepted request.
- R9: While a frame is being sent, no request is accepted. When requests are pending, the next frame starts exactly one idle cycle after the stop bit.
- R10: The start bit of a frame appears on `lane_b` in the cycle after the cycle in which its ready is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_accept | input | 1 | First-level accept for this bunch |
| crst_valid | input | 1 | Counter-reset request pending |
| crst_data | input | 8 | Counter-reset command byte |
| crst_ready | output | 1 | Counter-reset request taken |
| l2_valid | input | 1 | Second-level decision pending |
| l2_data | input | 8 | Second-level decision byte |
| l2_ready | output | 1 | Second-level request taken |
| ctl_valid | input | 1 | Control command pending |
| ctl_data | input | 8 | Control command byte |
| ctl_ready | output | 1 | Control request taken |
| dest_valid | input | 1 | Destination broadcast pending |
| dest_qual | input | 8 | Destination qualifier byte |
| dest_addr | input | 16 | Network destination address |
| dest_ready | output | 1 | Destination request taken |
| lane_a | output | 1 | Channel A slot (trigger accept) |
| lane_b | output | 1 | Channel B slot (broadcast bit stream) |

## Verification
Two events can fall in the same cycle: several sources requesting at once at the moment the channel becomes free, and a channel A accept bit that lands during a broadcast frame. The bench holds all four sources valid while a long frame is in flight, so the arbiter sees four requests in the cycle after the stop bit. The grant order, each frame's bit pattern and the one-cycle gaps are judged against a scoreboard. A pseudo-random accept pattern runs during the whole test, so every channel A slot is compared with the previous cycle's input while frames of both lengths are being sent.

// File: rtl/tbf_pkg.sv
package tbf_pkg;

    localparam int SDW   = 8;                         // short payload width
    localparam int LAW   = 8;                         // long qualifier width
    localparam int LDW   = 16;                        // long address width
    localparam int SCW   = 5;                         // short check bits
    localparam int LCW   = 6;                         // long check bits
    localparam int LRSV  = 9;                         // long reserved bits
    localparam int PW    = LAW + LDW;                 // widest protected payload
    localparam int HW    = 6;                         // check vector width
    localparam int SLEN  = 2 + SDW + SCW + 1;         // 16
    localparam int LLEN  = 2 + LAW + LDW + LCW + LRSV + 1; // 42
    localparam int FW    = LLEN;                      // shift register width
    localparam int CNTW  = $clog2(FW + 1);
    localparam int NSRC  = 4;

    typedef enum logic [1:0] {
        SRC_CRST = 2'd0,
        SRC_L2   = 2'd1,
        SRC_CTL  = 2'd2,
        SRC_DEST = 2'd3
    } src_e;

    // Positional parity over the first k bits of d.
    // Result: {overall, h4, h3, h2, h1, h0}.
    function automatic logic [HW-1:0] ham_check(input logic [PW-1:0] d, input int k);
        logic [HW-1:0] c;
        logic [7:0]    pos;
        c   = '0;
        pos = 8'd3;
        for (int j = 0; j < PW; j++) begin
            if (j < k) begin
                for (int i = 0; i < HW - 1; i++) begin
                    if (pos[i]) c[i] = c[i] ^ d[j];
                end
                pos = pos + 8'd1;
                if ((pos & (pos - 8'd1)) == 8'd0) pos = pos + 8'd1;
            end
        end
        c[HW-1] = (^d) ^ (^c[HW-2:0]);
        return c;
    endfunction

endpackage

// File: rtl/tbf_arb.sv
module tbf_arb #(
    parameter int N = 4
) (
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    for (genvar i = 0; i < N; i++) begin : g_pri
        if (i == 0) begin : g_top
            assign gnt[i] = en & req[i];
        end else begin : g_low
            assign gnt[i] = en & req[i] & ~(|req[i-1:0]);
        end
    end

endmodule

// File: rtl/tbf_framer.sv
module tbf_framer
    import tbf_pkg::*;
(
    input  logic [NSRC-1:0] gnt,
    input  logic [SDW-1:0]  crst_data,
    input  logic [SDW-1:0]  l2_data,
    input  logic [SDW-1:0]  ctl_data,
    input  logic [LAW-1:0]  dest_qual,
    input  logic [LDW-1:0]  dest_addr,
    output logic            load,
    output logic [FW-1:0]   frame,
    output logic [CNTW-1:0] len
);

    logic [SDW-1:0] sdata;
    logic [HW-1:0]  hs;
    logic [HW-1:0]  hl;
    logic [FW-1:0]  short_f;
    logic [FW-1:0]  long_f;

    always_comb begin
        if (gnt[SRC_CRST])    sdata = crst_data;
        else if (gnt[SRC_L2]) sdata = l2_data;
        else                  sdata = ctl_data;
    end

    assign hs = ham_check({{(PW-SDW){1'b0}}, sdata}, SDW);
    assign hl = ham_check({dest_qual, dest_addr}, PW);

    assign short_f = {1'b0, 1'b0, sdata, hs[HW-1], hs[SCW-2:0], 1'b1,
                      {(FW-SLEN){1'b0}}};
    assign long_f  = {1'b0, 1'b1, dest_qual, dest_addr, hl,
                      {LRSV{1'b0}}, 1'b1};

    assign load  = |gnt;
    assign frame = gnt[SRC_DEST] ? long_f : short_f;
    assign len   = gnt[SRC_DEST] ? CNTW'(LLEN) : CNTW'(SLEN);

endmodule

// File: rtl/tbf_lane_mux.sv
module tbf_lane_mux
    import tbf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig,
    input  logic            load,
    input  logic [FW-1:0]   frame,
    input  logic [CNTW-1:0] len,
    output logic            lane_a,
    output logic            lane_b,
    output logic            busy
);

    typedef struct packed {
        logic [FW-1:0]   sh;
        logic [CNTW-1:0] cnt;
        logic            a;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.a = trig;
        if (load) begin
            st_d.sh  = frame;
            st_d.cnt = len;
        end else if (st_q.cnt != '0) begin
            st_d.sh  = {st_q.sh[FW-2:0], 1'b1};
            st_d.cnt = st_q.cnt - CNTW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh  <= '1;
            st_q.cnt <= '0;
            st_q.a   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.cnt != '0);
    assign lane_b = busy ? st_q.sh[FW-1] : 1'b1;
    assign lane_a = st_q.a;

endmodule

// File: rtl/tbf_gen.sv
module tbf_gen
    import tbf_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trig_accept,
    input  logic           crst_valid,
    input  logic [SDW-1:0] crst_data,
    output logic           crst_ready,
    input  logic           l2_valid,
    input  logic [SDW-1:0] l2_data,
    output logic           l2_ready,
    input  logic           ctl_valid,
    input  logic [SDW-1:0] ctl_data,
    output logic           ctl_ready,
    input  logic           dest_valid,
    input  logic [LAW-1:0] dest_qual,
    input  logic [LDW-1:0] dest_addr,
    output logic           dest_ready,
    output logic           lane_a,
    output logic           lane_b
);

    logic [NSRC-1:0] req;
    logic [NSRC-1:0] gnt;
    logic            busy;
    logic            load;
    logic [FW-1:0]   frame;
    logic [CNTW-1:0] len;

    assign req = {dest_valid, ctl_valid, l2_valid, crst_valid};

    tbf_arb #(.N(NSRC)) arb_i (
        .en  (rst_n & ~busy),
        .req (req),
        .gnt (gnt)
    );

    tbf_framer framer_i (
        .gnt       (gnt),
        .crst_data (crst_data),
        .l2_data   (l2_data),
        .ctl_data  (ctl_data),
        .dest_qual (dest_qual),
        .dest_addr (dest_addr),
        .load      (load),
        .frame     (frame),
        .len       (len)
    );

    tbf_lane_mux lane_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig_accept),
        .load   (load),
        .frame  (frame),
        .len    (len),
        .lane_a (lane_a),
        .lane_b (lane_b),
        .busy   (busy)
    );

    assign crst_ready = gnt[SRC_CRST];
    assign l2_ready   = gnt[SRC_L2];
    assign ctl_ready  = gnt[SRC_CTL];
    assign dest_ready = gnt[SRC_DEST];

endmodule

// File: rtl/tbf_gen_chk.sv
module tbf_gen_chk
    import tbf_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           trig_accept,
    input logic           crst_valid,
    input logic [SDW-1:0] crst_data,
    input logic           crst_ready,
    input logic           l2_valid,
    input logic [SDW-1:0] l2_data,
    input logic           l2_ready,
    input logic           ctl_valid,
    input logic [SDW-1:0] ctl_data,
    input logic           ctl_ready,
    input logic           dest_valid,
    input logic [LAW-1:0] dest_qual,
    input logic [LDW-1:0] dest_addr,
    input logic           dest_ready,
    input logic           lane_a,
    input logic           lane_b
);

    logic [CNTW-1:0] left_q;
    logic            any_rdy;

    assign any_rdy = crst_ready | l2_ready | ctl_ready | dest_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          left_q <= '0;
        else if (dest_ready) left_q <= CNTW'(LLEN);
        else if (any_rdy)    left_q <= CNTW'(SLEN);
        else if (left_q != '0) left_q <= left_q - CNTW'(1);
    end

    // R8
    one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({crst_ready, l2_ready, ctl_ready, dest_ready}));

    // R8
    ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({crst_ready, l2_ready, ctl_ready, dest_ready} &
         ~{crst_valid, l2_valid, ctl_valid, dest_valid}) == 4'b0);

    // R8
    prio_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crst_valid |-> !(l2_ready | ctl_ready | dest_ready));

    // R8
    prio_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l2_valid |-> !(ctl_ready | dest_ready));

    // R8
    prio_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_valid |-> !dest_ready);

    // R9
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q != '0) |-> !any_rdy);

    // R10
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_rdy |=> !lane_b);

    // R4
    stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q == CNTW'(1)) |-> lane_b);

    // R3
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q == '0) |-> lane_b);

    // R2
    lane_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lane_a == $past(trig_accept)));

endmodule

bind tbf_gen tbf_gen_chk chk_i (.*);

// File: tb/tbf_gen_tb_top.sv
module tbf_gen_tb_top;

    typedef struct {
        int          len;
        logic [41:0] bits;
        int          tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_accept = 1'b0;
    logic        crst_valid = 1'b0, l2_valid = 1'b0, ctl_valid = 1'b0, dest_valid = 1'b0;
    logic [7:0]  crst_data = '0, l2_data = '0, ctl_data = '0, dest_qual = '0;
    logic [15:0] dest_addr = '0;
    logic        crst_ready, l2_ready, ctl_ready, dest_ready;
    logic        lane_a, lane_b;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    exp_t exp_q[$];
    int   order_q[$];
    int   start_q[$];
    int   len_q[$];
    bit   in_frame = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tbf_gen dut_i (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [5:0] ref_chk(input logic [23:0] d, input int k);
        logic [5:0] c = '0;
        int pos = 2;
        for (int j = 0; j < k; j++) begin
            pos++;
            while ((pos & (pos - 1)) == 0) pos++;
            for (int i = 0; i < 5; i++) if (pos[i]) c[i] ^= d[j];
        end
        c[5] = (^d) ^ (^c[4:0]);
        return c;
    endfunction

    function automatic exp_t mk_exp(input int src, input logic [7:0] q, input logic [15:0] w);
        exp_t e;
        logic [5:0] c;
        e.tag = src;
        if (src == 3) begin
            c      = ref_chk({q, w}, 24);
            e.len  = 42;
            e.bits = {2'b01, q, w, c, 9'b0, 1'b1};
        end else begin
            c      = ref_chk({16'b0, q}, 8);
            e.len  = 16;
            e.bits = {2'b00, q, c[5], c[3:0], 1'b1, 26'b0};
        end
        return e;
    endfunction

    function automatic logic rdy_of(input int src);
        case (src)
            0: return crst_ready;
            1: return l2_ready;
            2: return ctl_ready;
            default: return dest_ready;
        endcase
    endfunction

    task automatic set_valid(input int src, input logic v, input logic [7:0] q, input logic [15:0] w);
        case (src)
            0: begin crst_valid = v; crst_data = q; end
            1: begin l2_valid = v; l2_data = q; end
            2: begin ctl_valid = v; ctl_data = q; end
            default: begin dest_valid = v; dest_qual = q; dest_addr = w; end
        endcase
    endtask

    // Driver: raise a request, wait for its grant, push the expected frame.
    task automatic post(input int src, input logic [7:0] q, input logic [15:0] w);
        set_valid(src, 1'b1, q, w);
        #1;
        while (!rdy_of(src)) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(mk_exp(src, q, w));
        order_q.push_back(src);
        @(negedge clk);
        check(rdy_of(src) == 1'b0, "R8 ready lasts one cycle", rdy_of(src), 0);
        check(lane_b == 1'b0, "R10 start bit after ready", lane_b, 0);
        set_valid(src, 1'b0, q, w);
    endtask

    // Monitor: pop expected frames and compare them bit by bit.
    initial begin
        exp_t cur;
        int   idx = 0;
        bit   ok = 1'b1;
        logic [41:0] got = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!in_frame) begin
                    if (lane_b == 1'b0) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R3 unexpected frame start", 0, 1);
                        end else begin
                            cur = exp_q.pop_front();
                            in_frame = 1'b1;
                            idx = 1;
                            got = '0;
                            got[41] = lane_b;
                            ok = (lane_b == cur.bits[41]);
                            start_q.push_back(cyc);
                            len_q.push_back(cur.len);
                        end
                    end
                end else begin
                    got[41-idx] = lane_b;
                    if (lane_b != cur.bits[41-idx]) ok = 1'b0;
                    idx++;
                    if (idx == cur.len) begin
                        in_frame = 1'b0;
                        check(ok, (cur.len == 42) ? "R6 R7 long frame bits" : "R4 R5 short frame bits",
                              got, cur.bits);
                    end
                end
            end
        end
    end

    // Channel A pattern and check.
    initial begin
        logic [7:0] lfsr = 8'h5b;
        logic       last = 1'b0;
        bit         armed = 1'b0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (done) break;
            if (armed) check(lane_a == last, "R2 channel A follows accept", lane_a, last);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            last = lfsr[0];
            trig_accept = last;
            armed = 1'b1;
        end
    end

    task automatic wait_quiet();
        @(negedge clk);
        while (exp_q.size() != 0 || in_frame) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(lane_b == 1'b1, "R1 lane_b in reset", lane_b, 1);
        check(lane_a == 1'b0, "R1 lane_a in reset", lane_a, 0);
        check({crst_ready, l2_ready, ctl_ready, dest_ready} == 4'b0, "R1 no ready",
              {crst_ready, l2_ready, ctl_ready, dest_ready}, 0);
        rst_n = 1'b1;
        // R3 idle
        repeat (5) begin
            @(negedge clk);
            check(lane_b == 1'b1, "R3 idle high", lane_b, 1);
        end

        // R4 R5 single short frames from each short source
        post(0, 8'h00, 16'h0); wait_quiet();
        post(1, 8'hff, 16'h0); wait_quiet();
        post(2, 8'ha5, 16'h0); wait_quiet();
        post(0, 8'h3c, 16'h0); wait_quiet();
        post(2, 8'h01, 16'h0); wait_quiet();

        // R6 R7 long frames
        post(3, 8'h5a, 16'hbeef); wait_quiet();
        post(3, 8'h00, 16'h0001); wait_quiet();

        // R8 R9 all four pending while a long frame is in flight
        order_q.delete();
        n0 = start_q.size();
        post(3, 8'h81, 16'h1234);
        fork
            post(0, 8'h11, 16'h0);
            post(1, 8'h22, 16'h0);
            post(2, 8'h33, 16'h0);
            post(3, 8'h44, 16'habcd);
        join
        wait_quiet();
        for (int k = 0; k < 5; k++)
            check(order_q[k] == (k == 0 ? 3 : k - 1), "R8 grant order", order_q[k], (k == 0 ? 3 : k - 1));
        for (int k = n0 + 1; k < n0 + 5; k++)
            check(start_q[k] - start_q[k-1] == len_q[k-1] + 1, "R9 one idle cycle between frames",
                  start_q[k] - start_q[k-1], len_q[k-1] + 1);

        // R8 two middle sources together while idle
        order_q.delete();
        fork
            post(2, 8'h77, 16'h0);
            post(1, 8'h66, 16'h0);
        join
        wait_quiet();
        check(order_q[0] == 1 && order_q[1] == 2, "R8 l2 before control",
              {order_q[0], order_q[1]}, {32'd1, 32'd2});

        // R3 idle after traffic
        check(lane_b == 1'b1, "R3 idle after traffic", lane_b, 1);

        done = 1'b1;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule